// File: doc/BRIEF.md
# Chip Spreader and Offset-QPSK Half-Sine Modulator

This block sits in the transmit path of a 2.4 GHz low-rate personal-area-network radio. It takes the transmit payload one byte at a time and splits each byte into two 4-bit symbols. Each symbol is spread into a 32-chip pseudo-random code, and the block produces signed in-phase and quadrature sample words for a pair of DACs. Even-indexed chips drive the I rail and odd-indexed chips drive the Q rail. Each chip is shaped as a half-sine pulse that lasts two chip periods. Because the Q rail lags the I rail by one chip period, the result is a constant-envelope, MSK-like waveform.

The clock runs at the sample rate. The `step_en` input advances the waveform by one sample, and four steps make one chip period. At 2 Mchip/s, a steady `step_en` at 8 MHz gives 62.5 ksymbol/s, which is 250 kb/s. Bytes enter through a valid/ready handshake into a one-byte nibble buffer. If the buffer runs dry at the end of a symbol, the block drives zero samples and raises an idle flag until data arrives again.

Top module: `dsss_oqpsk_tx`

## Requirements
- R1: `in_ready` is high exactly when the nibble buffer holds no nibble. A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until both nibbles of that byte have been taken into symbols.
- R2: From each byte, the low nibble `[3:0]` is sent as a symbol first and the high nibble `[7:4]` second.
- R3: Chips are numbered 0 to 31, and chip 0 is sent first.
  - Symbol 0 uses the code 11011001110000110101001000101110, with chip 0 written leftmost.
  - Symbol k, for k from 1 to 7, is symbol 0 rotated toward higher chip indices by 4k positions, so chip i of symbol k equals chip (i-4k) mod 32 of symbol 0.
  - Symbol k+8 is symbol k with every odd-indexed chip inverted.
- R4: Even chip 2m sets the I pulse over chip periods 2m and 2m+1. Odd chip 2m+1 sets the Q pulse over chip periods 2m+1 and 2m+2, so Q lags I by one chip period.
- R5: Each pulse is 8 samples long, 4 per chip period. With the default 12-bit width, the magnitudes are 399, 1138, 1701, 2008, 2008, 1701, 1138, 399. A chip of 1 gives a positive two's-complement sample and a chip of 0 gives a negative one. While a symbol is being sent, the I sample is never zero.
- R6: Each rising edge with `step_en` high advances the waveform by one sample. With `step_en` low, `out_i`, `out_q` and `out_idle` keep their values.
- R7: Back-to-back symbols join with no gap. The Q pulse of chip 31 continues through chip period 0 of the next symbol.
- R8: Underflow and start-up behave as follows.
  - If the final sample of a symbol is stepped past while no nibble is buffered, `out_idle` goes high and both outputs read zero until a new symbol starts.
  - A symbol started from idle loads on a `step_en` edge.
  - A symbol started from idle has Q equal to zero during its chip period 0.
- R9: A synchronous reset clears the buffered nibbles, the chip and sample counters and the Q carry. After reset, `in_ready` is 1, `out_idle` is 1 and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance one sample (quarter chip) |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Transmit byte |
| in_ready | output | 1 | Nibble buffer empty, byte can be taken |
| out_i | output | SAMPLE_W | Signed I sample |
| out_q | output | SAMPLE_W | Signed Q sample |
| out_idle | output | 1 | No symbol in flight, outputs zero |

## Verification
The hardest case to reach is the seam between symbols. There, the Q half-pulse of one symbol's last chip must continue into the next symbol's first chip period. That only happens when the next byte arrives in time and no stall breaks the rhythm. The stimulus streams a table of bytes back to back, taking each one as soon as `in_ready` rises. It inserts single-cycle `step_en` stalls at irregular sample positions, so seams are crossed both with and without a stall nearby. A separate directed run enters a symbol from idle right after a mid-symbol reset. It checks that no stale Q carry survives and that an inverted-odd-chip symbol starts with the correct signs.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

    localparam int CHIPS_PER_SYM = 32;
    localparam int STEPS_PER_CHIP = 4;
    localparam int CHIP_W = $clog2(CHIPS_PER_SYM);
    localparam int STEP_W = $clog2(STEPS_PER_CHIP);

    // Spreading code of symbol zero; index 0 is the first chip on air.
    localparam logic [0:CHIPS_PER_SYM-1] BASE_CODE = 32'b11011001110000110101001000101110;

    typedef struct packed {
        logic              active;
        logic [3:0]        sym;
        logic [CHIP_W-1:0] chip;
        logic [STEP_W-1:0] step;
        logic              q_carry_vld;
        logic              q_carry;
    } tx_state_t;

    // Quarter-wave of a half-sine sampled at odd sixteenths of a period,
    // scaled to full positive range of a w-bit signed word.
    function automatic int half_sine_mag(input int w, input int p);
        int milli;
        case (p)
            0: milli = 195;
            1: milli = 556;
            2: milli = 831;
            default: milli = 981;
        endcase
        return (((1 << (w - 1)) - 1) * milli) / 1000;
    endfunction

endpackage

// File: rtl/dsss_nibble_buf.sv
module dsss_nibble_buf (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       rd_en,
    output logic [3:0] rd_nib,
    output logic       empty
);
    logic [7:0] data_d, data_q;
    logic [1:0] left_d, left_q;

    always_comb begin
        data_d = data_q;
        left_d = left_q;
        if (wr_en && left_q == 2'd0) begin
            data_d = wr_byte;
            left_d = 2'd2;
        end else if (rd_en && left_q != 2'd0) begin
            left_d = left_q - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            left_q <= '0;
        end else begin
            data_q <= data_d;
            left_q <= left_d;
        end
    end

    assign rd_nib = (left_q == 2'd2) ? data_q[3:0] : data_q[7:4];
    assign empty  = (left_q == 2'd0);
endmodule

// File: rtl/dsss_chip_map.sv
module dsss_chip_map
    import dsss_tx_pkg::*;
(
    input  logic [3:0]        sym,
    input  logic [CHIP_W-1:0] idx,
    output logic              chip
);
    logic [CHIP_W-1:0] shift;
    logic [CHIP_W-1:0] src;

    always_comb begin
        shift = CHIP_W'({sym[2:0], 2'b00});
        src   = idx - shift;
        chip  = BASE_CODE[src] ^ (sym[3] & idx[0]);
    end
endmodule

// File: rtl/dsss_shape_lut.sv
module dsss_shape_lut
    import dsss_tx_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [2:0]   pos,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] QUARTER [0:3] = '{
        W'(half_sine_mag(W, 0)),
        W'(half_sine_mag(W, 1)),
        W'(half_sine_mag(W, 2)),
        W'(half_sine_mag(W, 3))
    };

    logic [1:0] q_idx;

    always_comb begin
        q_idx = pos[2] ? ~pos[1:0] : pos[1:0];
        mag   = QUARTER[q_idx];
    end
endmodule

// File: rtl/dsss_oqpsk_tx.sv
module dsss_oqpsk_tx
    import dsss_tx_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step_en,
    input  logic                       in_valid,
    input  logic [7:0]                 in_byte,
    output logic                       in_ready,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q,
    output logic                       out_idle
);
    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(CHIPS_PER_SYM - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_CHIP - 1);
    localparam int LANES = 2;

    tx_state_t st_d, st_q;

    logic       buf_empty;
    logic [3:0] buf_nib;
    logic       buf_rd;

    logic [CHIP_W-1:0] lane_idx  [LANES];
    logic [2:0]        lane_pos  [LANES];
    logic              lane_chip [LANES];
    logic [SAMPLE_W-1:0] lane_mag [LANES];

    dsss_nibble_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_byte (in_byte),
        .rd_en   (buf_rd),
        .rd_nib  (buf_nib),
        .empty   (buf_empty)
    );

    // Lane 0 = I (even chip of the pair), lane 1 = Q (odd chip, one chip late)
    always_comb begin
        lane_idx[0] = {st_q.chip[CHIP_W-1:1], 1'b0};
        lane_pos[0] = {st_q.chip[0], st_q.step};
        lane_idx[1] = st_q.chip[0] ? st_q.chip : st_q.chip - CHIP_W'(1);
        lane_pos[1] = {~st_q.chip[0], st_q.step};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dsss_chip_map u_map (
            .sym  (st_q.sym),
            .idx  (lane_idx[g]),
            .chip (lane_chip[g])
        );
        dsss_shape_lut #(.W(SAMPLE_W)) u_lut (
            .pos (lane_pos[g]),
            .mag (lane_mag[g])
        );
    end

    logic at_end;
    logic q_live;
    logic q_bit;

    always_comb begin
        st_d   = st_q;
        buf_rd = 1'b0;
        at_end = st_q.active && st_q.chip == LAST_CHIP && st_q.step == LAST_STEP;
        if (step_en) begin
            if (st_q.active && !at_end) begin
                st_d.step = st_q.step + STEP_W'(1);
                if (st_q.step == LAST_STEP)
                    st_d.chip = st_q.chip + CHIP_W'(1);
            end else if (!buf_empty) begin
                buf_rd           = 1'b1;
                st_d.active      = 1'b1;
                st_d.sym         = buf_nib;
                st_d.chip        = '0;
                st_d.step        = '0;
                st_d.q_carry_vld = st_q.active;
                st_d.q_carry     = lane_chip[1];
            end else begin
                st_d.active      = 1'b0;
                st_d.q_carry_vld = 1'b0;
                st_d.q_carry     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        q_live = (st_q.chip != '0) || st_q.q_carry_vld;
        q_bit  = (st_q.chip == '0) ? st_q.q_carry : lane_chip[1];
        out_i  = '0;
        out_q  = '0;
        if (st_q.active) begin
            out_i = lane_chip[0] ? $signed(lane_mag[0]) : -$signed(lane_mag[0]);
            if (q_live)
                out_q = q_bit ? $signed(lane_mag[1]) : -$signed(lane_mag[1]);
        end
    end

    assign in_ready = buf_empty;
    assign out_idle = ~st_q.active;
endmodule

// File: rtl/dsss_oqpsk_tx_chk.sv
module dsss_oqpsk_tx_chk #(
    parameter int SAMPLE_W = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       step_en,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic signed [SAMPLE_W-1:0] out_i,
    input logic signed [SAMPLE_W-1:0] out_q,
    input logic                       out_idle
);
    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(out_i) && $stable(out_q) && $stable(out_idle)));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_idle |-> (out_i == '0 && out_q == '0));

    // R5
    i_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_idle |-> (out_i != '0));
endmodule

bind dsss_oqpsk_tx dsss_oqpsk_tx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (.*);

// File: tb/dsss_oqpsk_tx_tb_top.sv
`timescale 1ns/1ps
module dsss_oqpsk_tx_tb_top;
    localparam int W = 12;
    localparam int NB = 6;
    localparam int NSYM = 2 * NB;
    localparam logic [7:0] STIM [0:NB-1] = '{8'h10, 8'hF1, 8'h5A, 8'h87, 8'h3C, 8'hE2};
    localparam logic [0:31] SEQ0 = 32'b11011001110000110101001000101110;
    localparam int MAGS [0:7] = '{399, 1138, 1701, 2008, 2008, 1701, 1138, 399};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready;
    logic signed [W-1:0] out_i, out_q;
    logic out_idle;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dsss_oqpsk_tx #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst(rst), .step_en(step_en),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_i(out_i), .out_q(out_q), .out_idle(out_idle)
    );

    function automatic bit chip_ref(input int sym, input int i);
        int src;
        src = (i + 32 - 4 * (sym % 8)) % 32;
        return SEQ0[src] ^ ((sym >= 8) && (i % 2 == 1));
    endfunction

    function automatic int sym_of(input int n);
        return (n % 2 == 0) ? int'(STIM[n/2][3:0]) : int'(STIM[n/2][7:4]);
    endfunction

    function automatic int pulse(input bit c, input int pos);
        return c ? MAGS[pos] : -MAGS[pos];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic st, input logic v, input logic [7:0] b, output bit acc);
        step_en  = st;
        in_valid = v;
        in_byte  = b;
        acc = v && in_ready;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected samples for symbol n (first symbol after idle when n == 0)
    task automatic expect_at(input int n, input int c, input int p, input string tag);
        int s, ei, eq;
        s  = sym_of(n);
        ei = pulse(chip_ref(s, c - (c % 2)), (c % 2) * 4 + p);
        if (c % 2 == 1)      eq = pulse(chip_ref(s, c), p);
        else if (c == 0)     eq = (n == 0) ? 0 : pulse(chip_ref(sym_of(n - 1), 31), 4 + p);
        else                 eq = pulse(chip_ref(s, c - 1), 4 + p);
        check(int'(out_i) == ei, {tag, " I"}, int'(out_i), ei);
        check(int'(out_q) == eq, {tag, " Q"}, int'(out_q), eq);
        check(out_idle == 1'b0, {tag, " idle"}, int'(out_idle), 0);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit acc;
        int k, n, c, p, t, waitc;
        string tag;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(in_ready == 1'b1, "R9 ready", int'(in_ready), 1);
        check(out_idle == 1'b1, "R9 idle", int'(out_idle), 1);
        check(out_i == 0 && out_q == 0, "R9 zero", int'(out_i), 0);

        k = 0;
        tick(1'b1, 1'b1, STIM[0], acc);
        if (acc) k++;
        waitc = 0;
        while (out_idle && waitc < 20) begin
            tick(1'b1, k < NB, (k < NB) ? STIM[k] : 8'h00, acc);
            if (acc) k++;
            waitc++;
        end
        // R1 buffer still holds the high nibble
        check(in_ready == 1'b0, "R1 ready low", int'(in_ready), 0);

        // Stream: R2 R3 R4 R5 R7, stalls for R6
        n = 0; c = 0; p = 0; t = 0;
        while (n < NSYM) begin
            if (c == 0 && n > 0) tag = "R7 seam";
            else if (n == 0)     tag = "R2 R3 R4 R5 first";
            else                 tag = "R3 R4 R5";
            expect_at(n, c, p, tag);
            if (t % 37 == 5) begin
                tick(1'b0, k < NB, (k < NB) ? STIM[k] : 8'h00, acc);
                if (acc) k++;
                expect_at(n, c, p, "R6 stall");
            end
            t++;
            tick(1'b1, k < NB, (k < NB) ? STIM[k] : 8'h00, acc);
            if (acc) k++;
            p++;
            if (p == 4) begin p = 0; c++; end
            if (c == 32) begin c = 0; n++; end
        end
        // R8 underflow
        check(out_idle == 1'b1, "R8 idle", int'(out_idle), 1);
        check(out_i == 0, "R8 I zero", int'(out_i), 0);
        check(out_q == 0, "R8 Q zero", int'(out_q), 0);
        check(in_ready == 1'b1, "R1 ready empty", int'(in_ready), 1);

        // R9 mid-symbol reset
        tick(1'b1, 1'b1, 8'h00, acc);
        tick(1'b1, 1'b0, 8'h00, acc);
        check(out_idle == 1'b0, "R9 started", int'(out_idle), 0);
        for (int i = 0; i < 7; i++) tick(1'b1, 1'b0, 8'h00, acc);
        rst = 1'b1;
        tick(1'b1, 1'b1, 8'hFF, acc);
        rst = 1'b0;
        check(out_idle == 1'b1, "R9 idle after", int'(out_idle), 1);
        check(in_ready == 1'b1, "R9 buffer cleared", int'(in_ready), 1);
        check(out_i == 0 && out_q == 0, "R9 outputs zero", int'(out_i), 0);
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 8'h00, acc);
        check(out_idle == 1'b1, "R9 stays idle", int'(out_idle), 1);

        // R8 R3: symbol 8 from idle, Q zero in chip 0
        tick(1'b1, 1'b1, 8'h08, acc);
        tick(1'b1, 1'b0, 8'h00, acc);
        check(int'(out_i) == pulse(chip_ref(8, 0), 0), "R8 sym8 I", int'(out_i), pulse(chip_ref(8, 0), 0));
        check(out_q == 0, "R8 no stale Q", int'(out_q), 0);
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 8'h00, acc);
        check(int'(out_q) == pulse(chip_ref(8, 1), 0), "R3 odd inverted", int'(out_q), pulse(chip_ref(8, 1), 0));
        check(int'(out_i) == pulse(chip_ref(8, 0), 4), "R4 I second half", int'(out_i), pulse(chip_ref(8, 0), 4));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule